// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Mailbox

The mailbox joins two processors, called side A and side B, that each see an identical 32-bit register window. Each side owns four outgoing data lanes and four incoming data lanes. A word that one side stores into outgoing lane n is delivered to incoming lane n of the other side. Per-lane flags in the status word tell the writer when its outgoing lane has drained, and tell the reader when its incoming lane holds a word. Longer messages go out by using lanes 0, 1, 2, 3, 0, ... in turn. Before reusing a lane, the writer waits for that lane's empty flag.

Beside the data lanes, each side can ring four doorbells on the other side. Setting a request bit in the control word makes the matching pending flag rise on the other side. The request bit drops by itself once that flag is seen. The reader acknowledges a doorbell by writing one to the pending flag. Each side has one interrupt output. It is the OR of every status flag that is gated by its enable in that side's control word.

Register word offsets (byte addresses, word aligned): outgoing lane n at 0x00+4n, incoming lane n at 0x10+4n, status at 0x20, control at 0x24. Inside each nibble of the status and control words, index 0 sits in the most significant bit and index n sits at bit base+(3-n).

Top module: `ipcmb_top`

## Requirements
- R1: After reset the control word of both sides reads 0x00000000, the status word of both sides reads 0x00F00000 (all outgoing lanes empty, nothing full, nothing pending), and both interrupt outputs are low.
- R2: A write to offset 0x00+4n on one side stores the word in lane n. It clears that side's outgoing-empty bit 20+(3-n) and sets the other side's incoming-full bit 24+(3-n) from the next cycle on.
- R3: A read of offset 0x10+4n returns the word in incoming lane n. It then clears the reader's full bit 24+(3-n) and sets the writer's empty bit 20+(3-n) again.
- R4: When the writer stores to lane n in the same cycle that the reader reads lane n, the read returns the old word. The lane then stays full and holds the new word.
- R5: Writing 1 to control bit 16+(3-n) raises a request. One cycle later the other side's pending bit 28+(3-n) is set. The request bit reads 1 until the cycle after pending is set, and 0 afterwards. Writing 0 to a request bit has no effect.
- R6: Writing 1 to status bit 28+(3-n) clears that pending flag, and writing 0 leaves it. If a clear meets a still-active request for the same index in the same cycle, the flag stays set.
- R7: Status bits 27:20 and 19:0 are read-only, and a status write leaves them unchanged. Outgoing lanes, offsets 0x28 to 0x3C, and any access with address bits 1:0 not zero read as 0. A misaligned access changes no state.
- R8: A side's interrupt is high exactly when, for some n, one of these holds: pending with enable bit 28+(3-n); incoming full with enable bit 24+(3-n); outgoing empty with enable bit 20+(3-n).
- R9: Control bits 31:20 are read/write, bits 15:0 read 0, and read data is 0 in any cycle without a read access.
- R10: The four lanes of each direction are independent. Four words written to lanes 0 to 3 in turn are read back unchanged in the same rotation.
- R11: Side B behaves toward side A exactly as side A behaves toward side B, with the same register map.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_en | input | 1 | Side A access strobe |
| a_we | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 6 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data (combinational) |
| a_irq | output | 1 | Side A interrupt |
| b_en | input | 1 | Side B access strobe |
| b_we | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 6 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data (combinational) |
| b_irq | output | 1 | Side B interrupt |

## Verification
Two things can collide in one cycle. One is a writer storing to a lane while the reader drains the same lane. The other is a doorbell acknowledge that arrives while the request that raised the doorbell is still active. The bench drives both sides in the same cycle to provoke each collision. A behavioural model of the lanes, flags and enables predicts read data and interrupts for both sides on every clock. Explicit checks then confirm the outcome: the old word is returned and the new word is kept, and the pending flag survives the clear.

// File: rtl/ipcmb_pkg.sv
package ipcmb_pkg;

    localparam int DW      = 32;
    localparam int AW      = 6;
    localparam int NLANE   = 4;
    localparam int WIDX_W  = AW - 2;

    // nibble bases inside status / control words
    localparam int PEND_MSB  = 31;
    localparam int FULL_MSB  = 27;
    localparam int EMPTY_MSB = 23;
    localparam int REQ_MSB   = 19;

    typedef enum logic [WIDX_W-1:0] {
        RW_TX0  = 4'd0,
        RW_TX1  = 4'd1,
        RW_TX2  = 4'd2,
        RW_TX3  = 4'd3,
        RW_RX0  = 4'd4,
        RW_RX1  = 4'd5,
        RW_RX2  = 4'd6,
        RW_RX3  = 4'd7,
        RW_STAT = 4'd8,
        RW_CTRL = 4'd9
    } reg_word_e;

    typedef logic [NLANE-1:0]         lane_mask_t;
    typedef logic [NLANE-1:0][DW-1:0] word_vec_t;

    typedef struct packed {
        logic          en;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } bus_req_t;

    // enables and requests kept in index order (bit n = index n)
    typedef struct packed {
        lane_mask_t gie;
        lane_mask_t rie;
        lane_mask_t tie;
        lane_mask_t req;
    } ctrl_t;

    // index n <-> bit (3-n) of a nibble
    function automatic lane_mask_t rev4(input lane_mask_t v);
        lane_mask_t r;
        for (int i = 0; i < NLANE; i++) begin
            r[i] = v[NLANE-1-i];
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] pack_status(input lane_mask_t pend,
                                                  input lane_mask_t full,
                                                  input lane_mask_t empty);
        return {rev4(pend), rev4(full), rev4(empty), 20'h0};
    endfunction

    function automatic logic [DW-1:0] pack_ctrl(input ctrl_t c);
        return {rev4(c.gie), rev4(c.rie), rev4(c.tie), rev4(c.req), 16'h0};
    endfunction

endpackage

// File: rtl/ipcmb_lane.sv
module ipcmb_lane
    import ipcmb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    output logic [DW-1:0] data,
    output logic          full
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            full <= 1'b0;
        end else if (wr) begin
            data <= wdata;
            full <= 1'b1;
        end else if (rd) begin
            full <= 1'b0;
        end
    end

    // R2
    wr_sets_full_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> full);

    // R3
    rd_drains_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && !wr) |=> !full);

    // R4
    wr_beats_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && rd) |=> (full && data == $past(wdata)));

endmodule

// File: rtl/ipcmb_side.sv
module ipcmb_side
    import ipcmb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  bus_req_t      bus,
    output logic [DW-1:0] rdata,
    output logic          irq,
    output lane_mask_t    tx_wr,
    output logic [DW-1:0] tx_wdata,
    input  lane_mask_t    tx_full,
    output lane_mask_t    rx_rd,
    input  word_vec_t     rx_data,
    input  lane_mask_t    rx_full,
    output lane_mask_t    req,
    output lane_mask_t    pend,
    input  lane_mask_t    peer_req,
    input  lane_mask_t    peer_pend
);

    logic [WIDX_W-1:0] widx;
    reg_word_e         word;
    logic              aligned;
    logic              acc_wr;
    logic              acc_rd;
    logic              stat_wr;
    logic              ctrl_wr;
    lane_mask_t        clr_mask;
    lane_mask_t        raise_mask;
    ctrl_t             ctrl_q;
    lane_mask_t        pend_q;

    assign widx    = bus.addr[AW-1:2];
    assign word    = reg_word_e'(widx);
    assign aligned = (bus.addr[1:0] == 2'b00);
    assign acc_wr  = bus.en &  bus.we & aligned;
    assign acc_rd  = bus.en & ~bus.we & aligned;
    assign stat_wr = acc_wr && (word == RW_STAT);
    assign ctrl_wr = acc_wr && (word == RW_CTRL);

    assign clr_mask   = stat_wr ? rev4(bus.wdata[PEND_MSB -: NLANE]) : '0;
    assign raise_mask = ctrl_wr ? rev4(bus.wdata[REQ_MSB  -: NLANE]) : '0;

    generate
        for (genvar n = 0; n < NLANE; n++) begin : g_dec
            assign tx_wr[n] = acc_wr && (widx == WIDX_W'(n));
            assign rx_rd[n] = acc_rd && (widx == WIDX_W'(NLANE + n));
        end
    endgenerate

    assign tx_wdata = bus.wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            pend_q <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q.gie <= rev4(bus.wdata[PEND_MSB  -: NLANE]);
                ctrl_q.rie <= rev4(bus.wdata[FULL_MSB  -: NLANE]);
                ctrl_q.tie <= rev4(bus.wdata[EMPTY_MSB -: NLANE]);
            end
            ctrl_q.req <= (ctrl_q.req & ~peer_pend) | raise_mask;
            pend_q     <= (pend_q & ~clr_mask) | peer_req;
        end
    end

    assign req  = ctrl_q.req;
    assign pend = pend_q;

    always_comb begin
        rdata = '0;
        if (acc_rd) begin
            if (widx[WIDX_W-1:2] == 2'b01) begin
                rdata = rx_data[widx[1:0]];
            end else if (word == RW_STAT) begin
                rdata = pack_status(pend_q, rx_full, ~tx_full);
            end else if (word == RW_CTRL) begin
                rdata = pack_ctrl(ctrl_q);
            end
        end
    end

    assign irq = |((pend_q & ctrl_q.gie) | (rx_full & ctrl_q.rie) | (~tx_full & ctrl_q.tie));

    generate
        for (genvar n = 0; n < NLANE; n++) begin : g_chk
            // R5
            pend_cause_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(pend_q[n]) |-> $past(peer_req[n]));

            // R5
            req_drop_chk: assert property (@(posedge clk) disable iff (rst)
                (ctrl_q.req[n] && peer_pend[n] && !raise_mask[n]) |=> !ctrl_q.req[n]);

            // R6
            w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
                (stat_wr && bus.wdata[PEND_MSB-n] && !peer_req[n]) |=> !pend_q[n]);
        end
    endgenerate

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.gie == '0 && ctrl_q.rie == '0 && ctrl_q.tie == '0) |-> !irq);

endmodule

// File: rtl/ipcmb_top.sv
module ipcmb_top
    import ipcmb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq
);

    bus_req_t   a_bus, b_bus;
    lane_mask_t a_tx_wr, b_tx_wr, a_rx_rd, b_rx_rd;
    logic [DW-1:0] a_tx_wdata, b_tx_wdata;
    word_vec_t  ab_data, ba_data;
    lane_mask_t ab_full, ba_full;
    lane_mask_t a_req, b_req, a_pend, b_pend;

    assign a_bus = '{en: a_en, we: a_we, addr: a_addr, wdata: a_wdata};
    assign b_bus = '{en: b_en, we: b_we, addr: b_addr, wdata: b_wdata};

    generate
        for (genvar n = 0; n < NLANE; n++) begin : g_lane
            ipcmb_lane i_ab (
                .clk   (clk),
                .rst   (rst),
                .wr    (a_tx_wr[n]),
                .wdata (a_tx_wdata),
                .rd    (b_rx_rd[n]),
                .data  (ab_data[n]),
                .full  (ab_full[n])
            );
            ipcmb_lane i_ba (
                .clk   (clk),
                .rst   (rst),
                .wr    (b_tx_wr[n]),
                .wdata (b_tx_wdata),
                .rd    (a_rx_rd[n]),
                .data  (ba_data[n]),
                .full  (ba_full[n])
            );
        end
    endgenerate

    ipcmb_side i_side_a (
        .clk       (clk),
        .rst       (rst),
        .bus       (a_bus),
        .rdata     (a_rdata),
        .irq       (a_irq),
        .tx_wr     (a_tx_wr),
        .tx_wdata  (a_tx_wdata),
        .tx_full   (ab_full),
        .rx_rd     (a_rx_rd),
        .rx_data   (ba_data),
        .rx_full   (ba_full),
        .req       (a_req),
        .pend      (a_pend),
        .peer_req  (b_req),
        .peer_pend (b_pend)
    );

    ipcmb_side i_side_b (
        .clk       (clk),
        .rst       (rst),
        .bus       (b_bus),
        .rdata     (b_rdata),
        .irq       (b_irq),
        .tx_wr     (b_tx_wr),
        .tx_wdata  (b_tx_wdata),
        .tx_full   (ba_full),
        .rx_rd     (b_rx_rd),
        .rx_data   (ab_data),
        .rx_full   (ab_full),
        .req       (b_req),
        .pend      (b_pend),
        .peer_req  (a_req),
        .peer_pend (a_pend)
    );

    // R11
    sym_full_chk: assert property (@(posedge clk) disable iff (rst)
        (b_tx_wr != '0) |=> ((ba_full & $past(b_tx_wr)) == $past(b_tx_wr)));

endmodule

// File: tb/test_ipcmb_top.sv
`timescale 1ns/1ps
module test_ipcmb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        en [2];
    logic        we [2];
    logic [5:0]  ad [2];
    logic [31:0] wd [2];

    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    ipcmb_top i_ipcmb_top (
        .clk(clk), .rst(rst),
        .a_en(en[0]), .a_we(we[0]), .a_addr(ad[0]), .a_wdata(wd[0]),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_en(en[1]), .b_we(we[1]), .b_addr(ad[1]), .b_wdata(wd[1]),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    // reference model: direction d carries words written by side d
    logic [31:0] m_data [2][4];
    bit          m_full [2][4];
    bit          m_gie [2][4], m_rie [2][4], m_tie [2][4], m_req [2][4], m_pend [2][4];

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] got [2];
    bit          done = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_rdata(int s);
        logic [31:0] r = '0;
        int w = int'(ad[s][5:2]);
        if (!en[s] || we[s] || ad[s][1:0] != 2'b00) return '0;
        if (w >= 4 && w < 8) r = m_data[1-s][w-4];
        else if (w == 8) begin
            for (int n = 0; n < 4; n++) begin
                r[31-n] = m_pend[s][n];
                r[27-n] = m_full[1-s][n];
                r[23-n] = !m_full[s][n];
            end
        end else if (w == 9) begin
            for (int n = 0; n < 4; n++) begin
                r[31-n] = m_gie[s][n];
                r[27-n] = m_rie[s][n];
                r[23-n] = m_tie[s][n];
                r[19-n] = m_req[s][n];
            end
        end
        return r;
    endfunction

    function automatic bit m_irq(int s);
        bit r = 0;
        for (int n = 0; n < 4; n++)
            r |= (m_pend[s][n] & m_gie[s][n]) | (m_full[1-s][n] & m_rie[s][n]) |
                 (!m_full[s][n] & m_tie[s][n]);
        return r;
    endfunction

    task automatic m_reset();
        for (int s = 0; s < 2; s++)
            for (int n = 0; n < 4; n++) begin
                m_data[s][n] = '0; m_full[s][n] = 0; m_gie[s][n] = 0; m_rie[s][n] = 0;
                m_tie[s][n] = 0; m_req[s][n] = 0; m_pend[s][n] = 0;
            end
    endtask

    task automatic m_update();
        bit o_req [2][4];
        bit o_pend [2][4];
        o_req = m_req;
        o_pend = m_pend;
        for (int s = 0; s < 2; s++) begin
            bit ok = en[s] && ad[s][1:0] == 2'b00;
            int w = int'(ad[s][5:2]);
            for (int n = 0; n < 4; n++) begin
                if (ok && we[s] && w == n) begin
                    m_data[s][n] = wd[s];
                    m_full[s][n] = 1;
                end else if (en[1-s] && !we[1-s] && ad[1-s][1:0] == 2'b00 &&
                             int'(ad[1-s][5:2]) == 4 + n) begin
                    m_full[s][n] = 0;
                end
                if (ok && we[s] && w == 9) begin
                    m_gie[s][n] = wd[s][31-n];
                    m_rie[s][n] = wd[s][27-n];
                    m_tie[s][n] = wd[s][23-n];
                end
                m_req[s][n] = (o_req[s][n] && !o_pend[1-s][n]) ||
                              (ok && we[s] && w == 9 && wd[s][19-n]);
                m_pend[s][n] = (o_pend[s][n] && !(ok && we[s] && w == 8 && wd[s][31-n])) ||
                               o_req[1-s][n];
            end
        end
    endtask

    // one clock: compare against model, then advance model
    task automatic step(string tag);
        #1;
        got[0] = a_rdata;
        got[1] = b_rdata;
        if (!rst) begin
            chk({tag, " A rdata"}, a_rdata, m_rdata(0));
            chk({tag, " B rdata"}, b_rdata, m_rdata(1));
            chk({tag, " A irq"}, {31'h0, a_irq}, {31'h0, m_irq(0)});
            chk({tag, " B irq"}, {31'h0, b_irq}, {31'h0, m_irq(1)});
        end
        @(posedge clk);
        if (rst) m_reset(); else m_update();
        @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            en[s] = 0; we[s] = 0; ad[s] = '0; wd[s] = '0;
        end
    endtask

    task automatic put(int s, bit w, logic [5:0] a, logic [31:0] d);
        en[s] = 1; we[s] = w; ad[s] = a; wd[s] = d;
    endtask

    task automatic wr1(int s, logic [5:0] a, logic [31:0] d, string tag);
        put(s, 1, a, d);
        step(tag);
    endtask

    task automatic rd1(int s, logic [5:0] a, string tag, output logic [31:0] v);
        put(s, 0, a, '0);
        step(tag);
        v = got[s];
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int s = 0; s < 2; s++) begin
            en[s] = 0; we[s] = 0; ad[s] = '0; wd[s] = '0;
        end
        m_reset();
        @(negedge clk);
        repeat (3) step("reset");
        rst = 0;

        // R1
        rd1(0, 6'h20, "R1", v); chk("R1 A status", v, 32'h00F00000);
        rd1(0, 6'h24, "R1", v); chk("R1 A ctrl", v, 32'h0);
        rd1(1, 6'h20, "R1", v); chk("R1 B status", v, 32'h00F00000);
        step("R9 idle");

        // R2 / R3
        wr1(0, 6'h00, 32'h11112222, "R2");
        rd1(0, 6'h20, "R2", v); chk("R2 A status", v, 32'h00700000);
        rd1(1, 6'h20, "R2", v); chk("R2 B status", v, 32'h08F00000);
        rd1(1, 6'h10, "R3", v); chk("R3 B rx0", v, 32'h11112222);
        rd1(0, 6'h20, "R3", v); chk("R3 A status", v, 32'h00F00000);

        // R10 rotation
        for (int i = 0; i < 4; i++) wr1(0, 6'(4*i), 32'hC0DE0000 + i, "R10");
        for (int i = 0; i < 4; i++) begin
            rd1(1, 6'(16 + 4*i), "R10", v);
            chk("R10 rotation", v, 32'hC0DE0000 + i);
        end

        // R4 collision
        wr1(0, 6'h04, 32'hAAAA0001, "R4");
        put(0, 1, 6'h04, 32'hBBBB0002);
        put(1, 0, 6'h14, '0);
        step("R4");
        chk("R4 old word", got[1], 32'hAAAA0001);
        rd1(1, 6'h14, "R4", v); chk("R4 new word", v, 32'hBBBB0002);

        // R5 doorbell
        wr1(0, 6'h24, 32'h00020000, "R5");
        rd1(0, 6'h24, "R5", v); chk("R5 req held", v, 32'h00020000);
        rd1(1, 6'h20, "R5", v); chk("R5 B pend", v, 32'h20F00000);
        rd1(0, 6'h24, "R5", v); chk("R5 req dropped", v, 32'h0);

        // R6 W1C
        wr1(1, 6'h20, 32'h0, "R6");
        rd1(1, 6'h20, "R6", v); chk("R6 zero write", v, 32'h20F00000);
        wr1(1, 6'h20, 32'h20000000, "R6");
        rd1(1, 6'h20, "R6", v); chk("R6 cleared", v, 32'h00F00000);
        wr1(0, 6'h24, 32'h00080000, "R6");
        step("R6");
        wr1(1, 6'h20, 32'h80000000, "R6");
        rd1(1, 6'h20, "R6", v); chk("R6 set wins", v, 32'h80F00000);
        wr1(1, 6'h20, 32'h80000000, "R6");
        rd1(1, 6'h20, "R6", v); chk("R6 cleared again", v, 32'h00F00000);

        // R7 read-only / unmapped / misaligned
        wr1(0, 6'h08, 32'h00000005, "R7");
        wr1(1, 6'h20, 32'hFFFFFFFF, "R7");
        rd1(1, 6'h20, "R7", v); chk("R7 ro status", v, 32'h02F00000);
        rd1(1, 6'h28, "R7", v); chk("R7 unmapped", v, 32'h0);
        rd1(1, 6'h00, "R7", v); chk("R7 tx reads zero", v, 32'h0);
        rd1(1, 6'h19, "R7", v); chk("R7 misaligned", v, 32'h0);
        rd1(1, 6'h20, "R7", v); chk("R7 no consume", v, 32'h02F00000);
        rd1(1, 6'h18, "R7", v); chk("R7 rx2", v, 32'h00000005);

        // R8 interrupt combining
        wr1(1, 6'h24, 32'h01000000, "R8");
        wr1(0, 6'h0C, 32'h00000033, "R8");
        step("R8"); chk("R8 rie irq", {31'h0, b_irq}, 32'h1);
        rd1(1, 6'h1C, "R8", v);
        step("R8"); chk("R8 rie drop", {31'h0, b_irq}, 32'h0);
        wr1(0, 6'h24, 32'h00800000, "R8");
        step("R8"); chk("R8 tie irq", {31'h0, a_irq}, 32'h1);
        wr1(0, 6'h00, 32'h00000044, "R8");
        step("R8"); chk("R8 tie drop", {31'h0, a_irq}, 32'h0);
        rd1(1, 6'h10, "R8", v);
        wr1(1, 6'h24, 32'h80000000, "R8");
        wr1(0, 6'h24, 32'h00080000, "R8");
        step("R8"); step("R8");
        chk("R8 gie irq", {31'h0, b_irq}, 32'h1);
        wr1(1, 6'h20, 32'h80000000, "R8");
        wr1(1, 6'h24, 32'h0, "R8");
        wr1(0, 6'h24, 32'h0, "R8");

        // R9 control readback
        wr1(0, 6'h24, 32'hFFFFFFFF, "R9");
        rd1(0, 6'h24, "R9", v); chk("R9 ctrl full", v, 32'hFFFF0000);
        step("R9");
        rd1(0, 6'h24, "R9", v); chk("R9 req self clear", v, 32'hFFF00000);
        wr1(0, 6'h24, 32'h0, "R9");
        wr1(1, 6'h20, 32'hF0000000, "R9");
        rd1(1, 6'h20, "R9", v); chk("R9 pend cleared", v, 32'h00F00000);

        // R11 reverse direction
        wr1(1, 6'h04, 32'h00000077, "R11");
        rd1(0, 6'h20, "R11", v); chk("R11 A status", v, 32'h04F00000);
        rd1(0, 6'h14, "R11", v); chk("R11 A rx1", v, 32'h00000077);
        wr1(1, 6'h24, 32'h00040000, "R11");
        step("R11");
        rd1(0, 6'h20, "R11", v); chk("R11 A pend", v, 32'h40F00000);
        wr1(0, 6'h20, 32'h40000000, "R11");
        step("R11");

        done = 1;
        summary();
        $finish;
    end

endmodule